// File: doc/BRIEF.md
# Scatter Descriptor Chain Walker

This block walks a linked list of 16-byte scatter/gather descriptors held in memory and turns each one into a single transfer request for a separate data mover. A one-cycle `go` pulse hands it the address of the first descriptor. It reads the four 32-bit words of that descriptor, presents the segment (buffer address, byte count, direction, ordering hint and timing mode) on the request port, and waits for the mover to report completion. It then either jumps to the next descriptor through that descriptor's own link pointer, or stops when the descriptor carries the end mark.

Each descriptor is four little-endian 32-bit words. Word 0 is the buffer address. Word 1 is the segment length in units of 8 bytes. Word 2 carries a control byte in bits 7:0, a mode byte in bits 15:8, and two bytes the walker ignores. Word 3 is the link to the next descriptor. Descriptors must sit on 8-byte boundaries. A misaligned pointer ends the walk with an error pulse. An entry whose length is zero produces no request.

The block does not move data itself and knows nothing about the device-side protocol. It only sequences the descriptor reads and the per-segment requests.

Top module: `dcw_chain_walker`

## Requirements
- R1: A descriptor at pointer P is read as four single-word reads at P, P+4, P+8 and P+12, in that order, each issued only after the previous word has returned. The words hold buffer address, length units, control/mode word and link, in that order.
- R2: `xfer_bytes` equals the length units of the current descriptor multiplied by 8.
- R3: In the control byte (word 2, bits 7:0), bit 4 drives `xfer_ordered` and bit 5 drives `xfer_write` (1 = host-to-device). `xfer_mode` is bits 11:8 of word 2, which are the low 4 bits of the mode byte. Bits 15:12 of word 2 are ignored.
- R4: `xfer_valid` stays high, with all request fields unchanged, until the cycle in which `xfer_done` is sampled high. No descriptor read is issued while a request is pending.
- R5: After an entry whose control bit 7 (end mark) is set, `walk_done` pulses for one cycle and `busy` falls in that same cycle. The link word of that entry is never used as a read address, even when it is nonzero.
- R6: After an entry without the end mark, the walk continues by reading the descriptor at that entry's link pointer.
- R7: A `go` pulse in the idle state whose start pointer has any of bits 2:0 set produces a one-cycle `walk_err` in the following cycle. No descriptor read and no request follow.
- R8: When an entry without the end mark has a link pointer with any of bits 2:0 set, the entry's own transfer (if any) still completes. `walk_err` then pulses, the walk stops, and no further reads occur.
- R9: An entry with zero length units issues no transfer request, and the walk proceeds exactly as it would have after a transfer.
- R10: A `go` pulse while `busy` is high is ignored. The walk in progress finishes unchanged.
- R11: After reset, `busy`, `walk_done`, `walk_err`, `mem_rd_en` and `xfer_valid` are all low.
- R12: `walk_done` and `walk_err` are never high together, and exactly one of them pulses when a walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, accepted only when idle |
| start_ptr | input | 32 | Address of the first descriptor |
| busy | output | 1 | High while a walk is in progress |
| walk_done | output | 1 | One-cycle pulse: chain ended normally |
| walk_err | output | 1 | One-cycle pulse: misaligned pointer, walk stopped |
| mem_rd_en | output | 1 | One-cycle read request for a descriptor word |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data word |
| xfer_valid | output | 1 | Segment request pending |
| xfer_addr | output | 32 | Segment buffer address |
| xfer_bytes | output | 35 | Segment length in bytes |
| xfer_write | output | 1 | 1 = host-to-device direction |
| xfer_ordered | output | 1 | Ordered-processing hint |
| xfer_mode | output | 4 | Timing mode for the segment |
| xfer_done | input | 1 | Data mover finished the pending segment |

## Verification
The assertions watch on every cycle the rules that need no memory contents. They check that a pending request holds steady until completion and never overlaps a descriptor read. They check that skipped entries never raise a request and that every read address is word-aligned. They check that a misaligned start produces an error in the next cycle, and that every fall of `busy` coincides with exactly one of the done and error pulses. The bench scenarios are needed to show that fields land in the right request port bits, that lengths scale by 8, and that the link is followed or left alone as the end mark dictates. They also cover the chains that mix skipped entries, bad links and a `go` issued mid-walk.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int ALIGN_BITS = 3;
  localparam int BYTE_SHIFT = 3;

  // control byte bit positions
  localparam int CTL_ORDERED = 4;
  localparam int CTL_WRITE   = 5;
  localparam int CTL_LAST    = 7;
  localparam int MODE_LSB    = 8;

  // word slots inside a descriptor
  localparam logic [IDX_W-1:0] SLOT_BUF  = IDX_W'(0);
  localparam logic [IDX_W-1:0] SLOT_LEN  = IDX_W'(1);
  localparam logic [IDX_W-1:0] SLOT_CTL  = IDX_W'(2);
  localparam logic [IDX_W-1:0] SLOT_LINK = IDX_W'(3);

  function automatic logic ptr_misaligned(input logic [WORD_W-1:0] p);
    return |p[ALIGN_BITS-1:0];
  endfunction

  function automatic logic [WORD_W+BYTE_SHIFT-1:0] units_to_bytes(input logic [WORD_W-1:0] u);
    return {u, {BYTE_SHIFT{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] slot_offset(input logic [IDX_W-1:0] idx);
    return WORD_W'(idx) << 2;
  endfunction
endpackage

// File: rtl/dcw_desc_capture.sv
module dcw_desc_capture
  import dcw_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [WORD_W-1:0] cap_word,
  output logic [WORD_W-1:0] buf_addr,
  output logic [WORD_W-1:0] len_units,
  output logic              ctl_ordered,
  output logic              ctl_write,
  output logic              ctl_last,
  output logic [MODE_W-1:0] seg_mode,
  output logic [WORD_W-1:0] link_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_addr    <= '0;
      len_units   <= '0;
      ctl_ordered <= 1'b0;
      ctl_write   <= 1'b0;
      ctl_last    <= 1'b0;
      seg_mode    <= '0;
      link_ptr    <= '0;
    end else if (cap_en) begin
      case (cap_idx)
        SLOT_BUF: buf_addr  <= cap_word;
        SLOT_LEN: len_units <= cap_word;
        SLOT_CTL: begin
          ctl_ordered <= cap_word[CTL_ORDERED];
          ctl_write   <= cap_word[CTL_WRITE];
          ctl_last    <= cap_word[CTL_LAST];
          seg_mode    <= cap_word[MODE_LSB +: MODE_W];
        end
        default:  link_ptr  <= cap_word;
      endcase
    end
  end
endmodule

// File: rtl/dcw_ctrl.sv
module dcw_ctrl
  import dcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] start_ptr,
  input  logic              mem_rd_valid,
  input  logic              seg_empty,
  input  logic              seg_last,
  input  logic [WORD_W-1:0] link_ptr,
  input  logic              xfer_done,
  output logic              mem_rd_en,
  output logic [WORD_W-1:0] mem_rd_addr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              xfer_valid,
  output logic              busy,
  output logic              walk_done,
  output logic              walk_err,
  output logic              ev_skip
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_EVAL, S_XFER, S_NEXT} st_t;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  st_t               state_q;
  logic [WORD_W-1:0] ptr_q;
  logic [IDX_W-1:0]  widx_q;
  logic              done_q, err_q;

  assign mem_rd_en   = (state_q == S_RD);
  assign mem_rd_addr = ptr_q + slot_offset(widx_q);
  assign cap_en      = (state_q == S_WAIT) && mem_rd_valid;
  assign cap_idx     = widx_q;
  assign xfer_valid  = (state_q == S_XFER);
  assign busy        = (state_q != S_IDLE);
  assign walk_done   = done_q;
  assign walk_err    = err_q;
  assign ev_skip     = (state_q == S_EVAL) && seg_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      widx_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (go) begin
          if (ptr_misaligned(start_ptr)) begin
            err_q <= 1'b1;
          end else begin
            ptr_q   <= start_ptr;
            widx_q  <= '0;
            state_q <= S_RD;
          end
        end
        S_RD:   state_q <= S_WAIT;
        S_WAIT: if (mem_rd_valid) begin
          if (widx_q == LAST_IDX) begin
            state_q <= S_EVAL;
          end else begin
            widx_q  <= widx_q + IDX_W'(1);
            state_q <= S_RD;
          end
        end
        S_EVAL: state_q <= seg_empty ? S_NEXT : S_XFER;
        S_XFER: if (xfer_done) state_q <= S_NEXT;
        S_NEXT: begin
          if (seg_last) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (ptr_misaligned(link_ptr)) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            ptr_q   <= link_ptr;
            widx_q  <= '0;
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcw_chain_walker.sv
module dcw_chain_walker
  import dcw_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  input  logic [WORD_W-1:0]            start_ptr,
  output logic                         busy,
  output logic                         walk_done,
  output logic                         walk_err,
  output logic                         mem_rd_en,
  output logic [WORD_W-1:0]            mem_rd_addr,
  input  logic                         mem_rd_valid,
  input  logic [WORD_W-1:0]            mem_rd_data,
  output logic                         xfer_valid,
  output logic [WORD_W-1:0]            xfer_addr,
  output logic [WORD_W+BYTE_SHIFT-1:0] xfer_bytes,
  output logic                         xfer_write,
  output logic                         xfer_ordered,
  output logic [MODE_W-1:0]            xfer_mode,
  input  logic                         xfer_done
);
  logic              cap_en;
  logic [IDX_W-1:0]  cap_idx;
  logic [WORD_W-1:0] len_units;
  logic [WORD_W-1:0] link_ptr;
  logic              ctl_last;
  logic              seg_empty;
  logic              seg_skip;

  dcw_desc_capture #(.MODE_W(MODE_W)) cap_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .cap_idx     (cap_idx),
    .cap_word    (mem_rd_data),
    .buf_addr    (xfer_addr),
    .len_units   (len_units),
    .ctl_ordered (xfer_ordered),
    .ctl_write   (xfer_write),
    .ctl_last    (ctl_last),
    .seg_mode    (xfer_mode),
    .link_ptr    (link_ptr)
  );

  assign seg_empty  = (len_units == '0);
  assign xfer_bytes = units_to_bytes(len_units);

  dcw_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .start_ptr    (start_ptr),
    .mem_rd_valid (mem_rd_valid),
    .seg_empty    (seg_empty),
    .seg_last     (ctl_last),
    .link_ptr     (link_ptr),
    .xfer_done    (xfer_done),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .cap_en       (cap_en),
    .cap_idx      (cap_idx),
    .xfer_valid   (xfer_valid),
    .busy         (busy),
    .walk_done    (walk_done),
    .walk_err     (walk_err),
    .ev_skip      (seg_skip)
  );
endmodule

// File: rtl/dcw_chain_walker_chk.sv
module dcw_chain_walker_chk
  import dcw_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         go,
  input logic [WORD_W-1:0]            start_ptr,
  input logic                         busy,
  input logic                         walk_done,
  input logic                         walk_err,
  input logic                         mem_rd_en,
  input logic [WORD_W-1:0]            mem_rd_addr,
  input logic                         xfer_valid,
  input logic                         xfer_done,
  input logic [WORD_W-1:0]            xfer_addr,
  input logic [WORD_W+BYTE_SHIFT-1:0] xfer_bytes,
  input logic                         xfer_write,
  input logic                         xfer_ordered,
  input logic [MODE_W-1:0]            xfer_mode,
  input logic                         seg_skip
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_bytes)
      && $stable(xfer_write) && $stable(xfer_ordered) && $stable(xfer_mode)));

  assert_no_read_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !mem_rd_en);

  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));

  assert_skip_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_skip |=> !xfer_valid);

  assert_bad_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && ptr_misaligned(start_ptr)) |=> (walk_err && !busy && !mem_rd_en));

  assert_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (walk_done ^ walk_err));

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_err));
endmodule

bind dcw_chain_walker dcw_chain_walker_chk #(.MODE_W(MODE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .go           (go),
  .start_ptr    (start_ptr),
  .busy         (busy),
  .walk_done    (walk_done),
  .walk_err     (walk_err),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_addr  (mem_rd_addr),
  .xfer_valid   (xfer_valid),
  .xfer_done    (xfer_done),
  .xfer_addr    (xfer_addr),
  .xfer_bytes   (xfer_bytes),
  .xfer_write   (xfer_write),
  .xfer_ordered (xfer_ordered),
  .xfer_mode    (xfer_mode),
  .seg_skip     (seg_skip)
);

// File: tb/dcw_chain_walker_tb.sv
`timescale 1ns/1ps
module dcw_chain_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [31:0] start_ptr = '0;
  logic        busy, walk_done, walk_err, mem_rd_en, xfer_valid;
  logic [31:0] mem_rd_addr, xfer_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic [34:0] xfer_bytes;
  logic        xfer_write, xfer_ordered;
  logic [3:0]  xfer_mode;
  logic        xfer_done = 1'b0;

  always #4 clk = ~clk;

  dcw_chain_walker dut_i (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // memory model: answer arrives on the negedge one cycle after the request
  logic [31:0] mem [64];
  logic        rd_pend = 1'b0;
  logic [31:0] pend_data = '0;
  logic [31:0] rd_log [16];
  int          rd_cnt = 0;

  always @(negedge clk) begin
    mem_rd_valid = rd_pend;
    mem_rd_data  = pend_data;
    rd_pend      = mem_rd_en;
    pend_data    = mem[mem_rd_addr[7:2]];
    if (mem_rd_en) begin
      if (rd_cnt < 16) rd_log[rd_cnt] = mem_rd_addr;
      rd_cnt++;
    end
  end

  // data mover model
  int          mover_delay = 0;
  int          wait_cnt = 0;
  int          req_cnt = 0;
  logic [31:0] lg_addr [8];
  logic [34:0] lg_bytes [8];
  logic        lg_wr [8];
  logic        lg_ord [8];
  logic [3:0]  lg_mode [8];

  always @(negedge clk) begin
    if (xfer_done) begin
      xfer_done = 1'b0;
    end else if (xfer_valid) begin
      if (wait_cnt >= mover_delay) begin
        if (req_cnt < 8) begin
          lg_addr[req_cnt]  = xfer_addr;
          lg_bytes[req_cnt] = xfer_bytes;
          lg_wr[req_cnt]    = xfer_write;
          lg_ord[req_cnt]   = xfer_ordered;
          lg_mode[req_cnt]  = xfer_mode;
        end
        req_cnt++;
        wait_cnt  = 0;
        xfer_done = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int base, input logic [31:0] a, input logic [31:0] units,
                          input logic [7:0] ctl, input logic [7:0] mode, input logic [31:0] link);
    mem[base/4]     = a;
    mem[base/4 + 1] = units;
    mem[base/4 + 2] = {8'hC3, 8'h5A, mode, ctl};
    mem[base/4 + 3] = link;
  endtask

  task automatic run_walk(input logic [31:0] sp, output bit got_done, output bit got_err);
    req_cnt = 0; rd_cnt = 0; got_done = 0; got_err = 0;
    @(negedge clk); go = 1'b1; start_ptr = sp;
    @(negedge clk); go = 1'b0;
    for (int i = 0; i < 400 && !got_done && !got_err; i++) begin
      if (walk_done) got_done = 1;
      if (walk_err) got_err = 1;
      if (walk_done && walk_err)
        check(0, "R12", "done and err together", 1, 0);
      if (!(got_done || got_err)) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic [34:0] b;
    logic        w;
    logic        o;
    logic [3:0]  m;
  } exp_req_t;

  localparam exp_req_t EXP_REQ [4] = '{
    '{a: 32'h1000, b: 35'd32, w: 1'b0, o: 1'b1, m: 4'h2},
    '{a: 32'h2000, b: 35'd8,  w: 1'b1, o: 1'b0, m: 4'h5},
    '{a: 32'h3000, b: 35'd16, w: 1'b0, o: 1'b0, m: 4'h3},
    '{a: 32'h4000, b: 35'd24, w: 1'b1, o: 1'b0, m: 4'h0}
  };

  typedef struct packed {
    logic [31:0] sp;
    logic [7:0]  nreq;
    logic [7:0]  first;
    logic [7:0]  nrd;
    logic [31:0] last_rd;
    logic        err;
  } scen_t;

  localparam scen_t SCEN [5] = '{
    '{sp: 32'h00, nreq: 8'd2, first: 8'd0, nrd: 8'd8, last_rd: 32'h2C, err: 1'b0},
    '{sp: 32'h40, nreq: 8'd1, first: 8'd2, nrd: 8'd8, last_rd: 32'h6C, err: 1'b0},
    '{sp: 32'h80, nreq: 8'd1, first: 8'd3, nrd: 8'd4, last_rd: 32'h8C, err: 1'b1},
    '{sp: 32'h0C, nreq: 8'd0, first: 8'd0, nrd: 8'd0, last_rd: 32'h0,  err: 1'b1},
    '{sp: 32'hA0, nreq: 8'd0, first: 8'd0, nrd: 8'd4, last_rd: 32'hAC, err: 1'b0}
  };

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit d, e;
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    // chain A: ordered read, then last write entry whose mode byte has high bits set
    put_desc(32'h00, 32'h1000, 32'd4, 8'h10, 8'h02, 32'h20);
    put_desc(32'h20, 32'h2000, 32'd1, 8'hA0, 8'h15, 32'h48);
    // chain B: zero-length entry skipped, then last
    put_desc(32'h40, 32'h9999, 32'd0, 8'h30, 8'h07, 32'h60);
    put_desc(32'h60, 32'h3000, 32'd2, 8'h80, 8'h03, 32'h0);
    // chain C: write entry with misaligned link
    put_desc(32'h80, 32'h4000, 32'd3, 8'h20, 8'hF0, 32'h84);
    // chain E: single last entry of zero length
    put_desc(32'hA0, 32'h5000, 32'd0, 8'h80, 8'h01, 32'h0);

    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy && !walk_done && !walk_err, "R11", "status after reset",
          {busy, walk_done, walk_err}, 0);
    check(!mem_rd_en && !xfer_valid, "R11", "read/request after reset",
          {mem_rd_en, xfer_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 5; s++) begin
      mover_delay = s;
      run_walk(SCEN[s].sp, d, e);
      check(e == SCEN[s].err && d == !SCEN[s].err, SCEN[s].err ? "R8" : "R5",
            $sformatf("scen %0d end kind", s), {d, e}, {!SCEN[s].err, SCEN[s].err});
      check(req_cnt == int'(SCEN[s].nreq), "R9", $sformatf("scen %0d request count", s),
            req_cnt, SCEN[s].nreq);
      check(rd_cnt == int'(SCEN[s].nrd), "R6", $sformatf("scen %0d read count", s),
            rd_cnt, SCEN[s].nrd);
      if (SCEN[s].nrd != 0) begin
        check(rd_log[0] == SCEN[s].sp, "R1", $sformatf("scen %0d first read", s),
              rd_log[0], SCEN[s].sp);
        check(rd_log[SCEN[s].nrd - 1] == SCEN[s].last_rd, "R5",
              $sformatf("scen %0d final read", s), rd_log[SCEN[s].nrd - 1], SCEN[s].last_rd);
      end
      for (int r = 0; r < int'(SCEN[s].nreq) && r < req_cnt; r++) begin
        exp_req_t x;
        x = EXP_REQ[int'(SCEN[s].first) + r];
        check(lg_addr[r] == x.a, "R1", "buffer address", lg_addr[r], x.a);
        check(lg_bytes[r] == x.b, "R2", "byte length", lg_bytes[r], x.b);
        check(lg_wr[r] == x.w, "R3", "write flag", lg_wr[r], x.w);
        check(lg_ord[r] == x.o, "R3", "ordered flag", lg_ord[r], x.o);
        check(lg_mode[r] == x.m, "R3", "mode", lg_mode[r], x.m);
      end
    end

    // R1: word order within a descriptor of chain A
    mover_delay = 0;
    run_walk(32'h00, d, e);
    for (int k = 0; k < 4; k++)
      check(rd_log[k] == 32'(4 * k), "R1", "word address order", rd_log[k], 4 * k);
    check(rd_log[4] == 32'h20, "R6", "link followed", rd_log[4], 32'h20);

    // R7: error pulse in the cycle after go, no reads
    rd_cnt = 0;
    @(negedge clk); go = 1'b1; start_ptr = 32'h44;
    @(negedge clk); go = 1'b0;
    check(walk_err && !busy, "R7", "error pulse timing", {walk_err, busy}, 2'b10);
    @(negedge clk);
    check(!walk_err, "R7", "error pulse width", walk_err, 0);
    repeat (3) @(negedge clk);
    check(rd_cnt == 0, "R7", "reads after bad start", rd_cnt, 0);

    // R4 / R10: slow mover, and a stray go while busy
    mover_delay = 6;
    fork
      run_walk(32'h00, d, e);
      begin
        repeat (5) @(negedge clk);
        go = 1'b1; start_ptr = 32'h0C;
        @(negedge clk); go = 1'b0;
      end
    join
    check(d && !e, "R10", "go while busy ignored", {d, e}, 2'b10);
    check(req_cnt == 2, "R4", "requests with slow mover", req_cnt, 2);
    check(lg_bytes[0] == 35'd32 && lg_addr[1] == 32'h2000, "R4", "fields held under delay",
          lg_addr[1], 32'h2000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule